// File: doc/BRIEF.md
# Retimed Link Input Port with SEC Correction

This block is the receiving front end of a router input port whose link is protected by a single-error-correcting Hamming code. Each arriving flit, a data word plus its check bits, is first caught in a retiming register. In the following cycle the registered flit is decoded, any single flipped bit is repaired, and the repaired data word is written into the port's input FIFO. Errors therefore never reach stored data. The correction step costs exactly one extra cycle on the link, and that cost does not depend on how many errors arrive.

The FIFO raises a back-pressure flag toward the upstream sender once its nominal depth is reached. The sender sees that flag one flit too late, because a flit may already sit in the retiming register. The FIFO therefore holds one slot beyond its nominal depth, so that this flit still has a place. The router crossbar drains the FIFO through a valid/ready read port. A pulse marks every flit whose code word needed a repair, and a sticky flag records any write that found no free slot.

Top module: `lcs_link_port`

## Requirements
- R1: While reset is high and in the first cycle after it, `out_valid`, `full`, `corr_pulse` and `ovf_err` are all 0.
- R2: A flit presented with `in_valid` at clock edge k into an empty buffer shows up on `out_valid`/`out_data` after edge k+1, with or without a bit error. This is exactly one cycle more than a direct write.
- R3: The code word numbers its positions from 1 and reserves the power-of-two positions for check bits. Data bit 0 upward fills the other positions in ascending order. Check bit i is the XOR of the data bits whose position has bit i set. A single flipped data bit is repaired before storage, so `out_data` equals the data as sent.
- R4: A single flipped check bit leaves the data untouched, so `out_data` equals the data as sent.
- R5: `corr_pulse` is high for exactly the one cycle after the launch edge of a flit that carries a single-bit error, and it is low for error-free flits and idle cycles.
- R6: Flits leave in the order in which they arrived, and `out_valid` is high whenever at least one flit is stored.
- R7: `full` is high exactly when the stored count is at least `NOM_DEPTH`.
- R8: The buffer holds `NOM_DEPTH`+1 flits. A sender that launches only while `full` is low never loses a flit, including the flit already in the retiming register when `full` rises.
- R9: A write that arrives while all `NOM_DEPTH`+1 slots are used, in the same cycle as a read, is accepted. The count stays at `NOM_DEPTH`+1 and `ovf_err` stays 0.
- R10: `ovf_err` is set only by a write into a completely occupied buffer with no read in the same cycle, and it then stays set until reset. It stays 0 for a sender that obeys `full`.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Flit present on the link |
| in_data | input | DATA_W | Data part of the incoming flit |
| in_chk | input | CHK_W | Hamming check bits of the incoming flit |
| full | output | 1 | Back-pressure to the sender: nominal depth reached |
| out_valid | output | 1 | A corrected flit is available at the FIFO head |
| out_ready | input | 1 | Crossbar takes the head flit |
| out_data | output | DATA_W | Corrected data at the FIFO head |
| corr_pulse | output | 1 | The flit in the retiming stage had a single-bit error |
| ovf_err | output | 1 | Sticky: a write found no free slot |

## Verification
The hardest situation to reach from the ports is a write landing on a buffer that already holds all `NOM_DEPTH`+1 flits while a read happens in the same cycle. A sender that obeys `full` can never bring this about. To get there, the stimulus first fills the buffer with the reader stalled. It then pushes one flit past the raised `full` flag and opens `out_ready` exactly on the edge where that flit leaves the retiming register. The filling step also exercises the in-flight flit absorbed by the extra slot. The rest of the run is seeded random traffic with random data-bit and check-bit flips and random reader stalls. That traffic is compared against a bench-side count and order model.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

    // Classification of a decoded syndrome.
    typedef enum logic [1:0] {
        SYN_CLEAN   = 2'd0,
        SYN_CHK_BIT = 2'd1,
        SYN_DAT_BIT = 2'd2,
        SYN_BEYOND  = 2'd3
    } syn_class_e;

    // Number of check bits needed for a single-error-correcting code over dw data bits.
    function automatic int calc_chk_w(input int dw);
        for (int p = 1; p < 31; p++) begin
            if ((1 << p) >= dw + p + 1) return p;
        end
        return 31;
    endfunction

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Code-word position (1-based) occupied by data bit idx.
    function automatic int data_cw_pos(input int idx);
        int seen;
        seen = 0;
        for (int p = 1; p < 65536; p++) begin
            if (!is_pow2(p)) begin
                if (seen == idx) return p;
                seen++;
            end
        end
        return 0;
    endfunction

    // Next index of a ring of the given size.
    function automatic int ring_next(input int cur, input int size);
        return (cur == size - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/lcs_retime.sv
module lcs_retime #(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic              vld_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  chk_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
        end
    end

    always_ff @(posedge clk) begin
        if (vld_i) begin
            data_o <= data_i;
            chk_o  <= chk_i;
        end
    end

endmodule

// File: rtl/lcs_sec_corr.sv
module lcs_sec_corr
    import lcs_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CHK_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              corr_o
);

    localparam int CW_LEN = DATA_W + CHK_W;

    logic [CHK_W-1:0] recomp;
    logic [CHK_W-1:0] syndrome;
    syn_class_e       syn_class;

    // Recompute check bits from the received data.
    for (genvar gb = 0; gb < CHK_W; gb++) begin : g_chk
        logic [DATA_W-1:0] tap;
        for (genvar gi = 0; gi < DATA_W; gi++) begin : g_tap
            localparam int POS = data_cw_pos(gi);
            assign tap[gi] = (((POS >> gb) & 1) != 0) ? data_i[gi] : 1'b0;
        end
        assign recomp[gb] = ^tap;
    end

    assign syndrome = recomp ^ chk_i;

    // Flip the data bit the syndrome points at, if any.
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_fix
        localparam int POS = data_cw_pos(gi);
        assign data_o[gi] = data_i[gi] ^ (syndrome == CHK_W'(POS));
    end

    always_comb begin
        if (syndrome == '0)
            syn_class = SYN_CLEAN;
        else if ($onehot(syndrome))
            syn_class = SYN_CHK_BIT;
        else if (int'(syndrome) <= CW_LEN)
            syn_class = SYN_DAT_BIT;
        else
            syn_class = SYN_BEYOND;
    end

    assign corr_o = vld_i && ((syn_class == SYN_CHK_BIT) || (syn_class == SYN_DAT_BIT));

    // R3: a data-bit syndrome changes exactly one data bit
    p_data_fix_one_bit_r3: assert property (@(posedge clk) disable iff (rst)
        (vld_i && syn_class == SYN_DAT_BIT) |-> ($countones(data_o ^ data_i) == 1));

    // R4: check-bit and clean syndromes leave the data untouched
    p_chk_fix_no_change_r4: assert property (@(posedge clk) disable iff (rst)
        (vld_i && (syn_class == SYN_CHK_BIT || syn_class == SYN_CLEAN)) |-> (data_o == data_i));

endmodule

// File: rtl/lcs_fifo.sv
module lcs_fifo
    import lcs_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NOM_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              full_o,
    output logic              rd_valid_o,
    input  logic              rd_ready_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ovf_o
);

    localparam int TOT_DEPTH = NOM_DEPTH + 1;
    localparam int PTR_W     = (TOT_DEPTH > 1) ? $clog2(TOT_DEPTH) : 1;
    localparam int CNT_W     = $clog2(TOT_DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_TOT = CNT_W'(TOT_DEPTH);
    localparam logic [CNT_W-1:0] CNT_NOM = CNT_W'(NOM_DEPTH);

    logic [DATA_W-1:0] slots [TOT_DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              all_used, rd_fire, wr_accept;

    assign all_used   = (count == CNT_TOT);
    assign rd_valid_o = (count != '0);
    assign rd_fire    = rd_valid_o && rd_ready_i;
    assign wr_accept  = wr_en_i && (!all_used || rd_fire);
    assign rd_data_o  = slots[rd_ptr];
    assign full_o     = (count >= CNT_NOM);

    always_ff @(posedge clk) begin
        if (wr_accept) slots[wr_ptr] <= wr_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf_o  <= 1'b0;
        end else begin
            if (wr_accept) wr_ptr <= PTR_W'(ring_next(int'(wr_ptr), TOT_DEPTH));
            if (rd_fire)   rd_ptr <= PTR_W'(ring_next(int'(rd_ptr), TOT_DEPTH));
            case ({wr_accept, rd_fire})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en_i && all_used && !rd_fire) ovf_o <= 1'b1;
        end
    end

    // R8: occupancy never exceeds nominal depth plus the extra slot
    p_cap_r8: assert property (@(posedge clk) disable iff (rst) count <= CNT_TOT);

    // R7: back-pressure only drops after a read
    p_full_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (full_o && !rd_fire) |=> full_o);

    // R9: write plus read at all-used keeps the buffer completely occupied
    p_wr_rd_at_top_r9: assert property (@(posedge clk) disable iff (rst)
        (all_used && wr_en_i && rd_fire) |=> (count == CNT_TOT));

    // R10: overflow flag is sticky
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o);

    // R11: a stalled head flit stays put
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

endmodule

// File: rtl/lcs_link_port.sv
module lcs_link_port
    import lcs_pkg::*;
#(
    parameter  int DATA_W    = 32,
    parameter  int NOM_DEPTH = 4,
    localparam int CHK_W     = calc_chk_w(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CHK_W-1:0]  in_chk,
    output logic              full,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              corr_pulse,
    output logic              ovf_err
);

    logic              rt_vld;
    logic [DATA_W-1:0] rt_data;
    logic [CHK_W-1:0]  rt_chk;
    logic [DATA_W-1:0] fixed_data;

    lcs_retime #(.DATA_W(DATA_W), .CHK_W(CHK_W)) retime_i (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (in_valid),
        .data_i (in_data),
        .chk_i  (in_chk),
        .vld_o  (rt_vld),
        .data_o (rt_data),
        .chk_o  (rt_chk)
    );

    lcs_sec_corr #(.DATA_W(DATA_W), .CHK_W(CHK_W)) corr_i (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (rt_vld),
        .data_i (rt_data),
        .chk_i  (rt_chk),
        .data_o (fixed_data),
        .corr_o (corr_pulse)
    );

    lcs_fifo #(.DATA_W(DATA_W), .NOM_DEPTH(NOM_DEPTH)) fifo_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en_i    (rt_vld),
        .wr_data_i  (fixed_data),
        .full_o     (full),
        .rd_valid_o (out_valid),
        .rd_ready_i (out_ready),
        .rd_data_o  (out_data),
        .ovf_o      (ovf_err)
    );

    // R5: the correction pulse only accompanies a flit in the retiming stage
    p_corr_with_flit_r5: assert property (@(posedge clk) disable iff (rst)
        corr_pulse |-> $past(in_valid));

    // R2: a registered flit reaches the buffer head one edge later
    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (rt_vld && !out_valid) |=> out_valid);

endmodule

// File: tb/lcs_link_port_tb_top.sv
module lcs_link_port_tb_top;

    localparam int DW  = 32;
    localparam int CW  = 6;
    localparam int NOM = 4;
    localparam int TOT = NOM + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [CW-1:0] in_chk = '0;
    logic          full, out_valid, corr_pulse, ovf_err;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    lcs_link_port #(.DATA_W(DW), .NOM_DEPTH(NOM)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_chk     (in_chk),
        .full       (full),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .corr_pulse (corr_pulse),
        .ovf_err    (ovf_err)
    );

    // Bench model state
    logic [DW-1:0] exp_q[$];
    int            kind_q[$];
    int            exp_cnt = 0;
    bit            l1 = 0, l2 = 0, l1_err = 0, r1 = 0;
    bit            hold_pending = 0;
    logic [DW-1:0] hold_data;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

    // Hamming check bits, following the position rule stated in R3
    function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
        logic [CW-1:0] c;
        int            di;
        c  = '0;
        di = 0;
        for (int p = 1; di < DW; p++) begin
            if (!pow2(p)) begin
                for (int b = 0; b < CW; b++)
                    if (((p >> b) & 1) != 0) c[b] ^= d[di];
                di++;
            end
        end
        return c;
    endfunction

    // One bench cycle at the falling edge: check outputs, then drive the next inputs.
    // err_kind: 0 clean, 1 flip a data bit, 2 flip a check bit
    task automatic cycle(input bit want, input bit force_send, input int err_kind, input bit ready);
        bit            launch, pop;
        logic [DW-1:0] d, sd;
        logic [CW-1:0] c;
        @(negedge clk);
        exp_cnt = exp_cnt + int'(l2) - int'(r1);
        check(out_valid == (exp_cnt != 0), "R2 R6 out_valid vs stored count", 64'(out_valid), 64'(exp_cnt != 0));
        check(full == (exp_cnt >= NOM), "R7 full flag", 64'(full), 64'(exp_cnt >= NOM));
        check(ovf_err == 1'b0, "R8 R10 no overflow", 64'(ovf_err), 64'd0);
        check(corr_pulse == l1_err, "R5 correction pulse", 64'(corr_pulse), 64'(l1_err));
        if (hold_pending) begin
            check(out_data == hold_data, "R11 head data held while stalled", 64'(out_data), 64'(hold_data));
        end
        hold_pending = out_valid && !ready;
        hold_data    = out_data;
        pop = out_valid && ready;
        if (pop) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected flit", 64'(out_data), 64'd0);
            end else begin
                int k;
                k = kind_q.pop_front();
                d = exp_q.pop_front();
                if (k == 1)
                    check(out_data == d, "R3 data-bit error repaired", 64'(out_data), 64'(d));
                else if (k == 2)
                    check(out_data == d, "R4 check-bit error leaves data", 64'(out_data), 64'(d));
                else
                    check(out_data == d, "R6 order and content", 64'(out_data), 64'(d));
            end
        end
        launch = want && (force_send || !full);
        d  = $urandom;
        c  = encode(d);
        sd = d;
        if (launch) begin
            if (err_kind == 1) sd[$urandom_range(DW - 1)] ^= 1'b1;
            if (err_kind == 2) c[$urandom_range(CW - 1)] ^= 1'b1;
            exp_q.push_back(d);
            kind_q.push_back(err_kind);
        end
        in_valid  = launch;
        in_data   = sd;
        in_chk    = c;
        out_ready = ready;
        l2     = l1;
        l1     = launch;
        l1_err = launch && (err_kind != 0);
        r1     = pop;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1c3));
        repeat (3) @(negedge clk);
        check(out_valid == 0 && full == 0 && corr_pulse == 0 && ovf_err == 0, "R1 outputs during reset",
              {60'd0, out_valid, full, corr_pulse, ovf_err}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && full == 0 && corr_pulse == 0 && ovf_err == 0, "R1 outputs after reset",
              {60'd0, out_valid, full, corr_pulse, ovf_err}, 64'd0);

        // R2: single flit with a data error into an empty buffer
        cycle(1, 0, 1, 0);
        cycle(0, 0, 0, 0);
        check(out_valid == 0, "R2 not yet visible one edge after launch", 64'(out_valid), 64'd0);
        cycle(0, 0, 0, 0);
        check(out_valid == 1, "R2 visible two edges after launch", 64'(out_valid), 64'd1);
        cycle(0, 0, 0, 1);
        cycle(0, 0, 0, 0);

        // R8: fill with the reader stalled; the in-flight flit lands in the extra slot
        for (int i = 0; i < 10; i++) cycle(1, 0, i % 3, 0);
        cycle(0, 0, 0, 0);
        check(exp_q.size() == TOT, "R8 flits accepted with reader stalled", 64'(exp_q.size()), 64'(TOT));

        // R9: push past full, read on the edge the flit is written
        cycle(1, 1, 0, 0);
        cycle(0, 0, 0, 1);
        cycle(0, 0, 0, 0);
        check(full == 1 && ovf_err == 0, "R9 write plus read at top keeps buffer full",
              {62'd0, full, ovf_err}, 64'h2);
        for (int i = 0; i < 12; i++) cycle(0, 0, 0, 1);

        // Random traffic
        for (int i = 0; i < 4000; i++) begin
            int ek;
            ek = int'($urandom_range(9));
            ek = (ek < 6) ? 0 : ((ek < 8) ? 1 : 2);
            cycle($urandom_range(99) < 70, 0, ek, $urandom_range(99) < 55);
        end
        for (int i = 0; i < 20; i++) cycle(0, 0, 0, 1);
        check(exp_q.size() == 0, "R6 all flits delivered", 64'(exp_q.size()), 64'd0);
        finish_run();
    end

endmodule